// File: doc/BRIEF.md
# Linked-List Summing Engine

This engine walks a singly linked list stored in a word-addressed RAM and returns the sum of the node values. A node at address P keeps its successor pointer in word P and its value in word P+1. A pointer of zero ends the list. A client places the head pointer on `head` and pulses `start`. The engine then reads the list through one synchronous read port and raises `done` for one cycle once `sum` holds the result.

The loop uses exactly one memory read port and one adder. It alternates two steps, so a fetch and an addition overlap in every cycle. One step reads the current pointer word and adds the previously fetched value into the sum. The other step reads the value word and forms the next value address from the pointer that has just arrived. The memory's one cycle of read latency and the adder therefore sit in different cycles, so the clock period is set by the slower of the two and not by their sum. Each node costs two cycles.

Top module: `lls_sum_engine`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done` and `mem_rd_en` are 0 and `sum` is 0.
- R2: When `start` is sampled high in idle with a nonzero head H, the cycle after that edge issues a read of address H (the pointer word), and `busy` is 1.
- R3: For each node at P, a read of P is followed in the very next cycle by a read of P+1. When the pointer read at P returned a nonzero N, the cycle after the read of P+1 reads N. `mem_rd_en` stays high with no gap until the last value word has been read.
- R4: A pointer word of zero ends the walk. Address 0 is never read as a node, and no read is issued after the read of the last value word.
- R5: `sum` equals the sum of all node values modulo 2^16. A value of zero does not end the list.
- R6: For a list of n ≥ 1 nodes, `done` is high for exactly one cycle, 2n+2 cycles after the start edge. In that cycle `busy` is 0. `busy` is 1 in every cycle from the start edge until then.
- R7: With a head of zero, `done` is high in the cycle after the start edge, `sum` is 0, and no memory read is issued.
- R8: `start` is ignored while `busy` is 1. The read sequence and the result are unchanged.
- R9: `sum` holds its value after `done` until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Begin a walk; sampled only in idle |
| head | input | 16 | Address of the first node; zero means an empty list |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse: `sum` is final |
| sum | output | 16 | Sum of node values, modulo 2^16 |
| mem_rd_en | output | 1 | Read strobe for the list RAM |
| mem_addr | output | 16 | Read address |
| mem_rdata | input | 16 | Read data, valid the cycle after the strobe |

## Verification
The assertions assume that `mem_rdata` carries the word at the address strobed in the previous cycle, with exactly one cycle of latency. They also assume that every list ends in a zero pointer without looping back on itself. The bench's RAM model always returns data after one cycle. Every list it builds is acyclic and sits below address 255, so each node's value word is still inside the model. Mid-walk `start` pulses are driven on purpose, because the design must ignore them.

// File: rtl/lls_pkg.sv
package lls_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HEAD,
    ST_VAL,
    ST_PTR,
    ST_TAIL,
    ST_LAST,
    ST_DONE
  } lls_state_e;

  typedef enum logic [1:0] {
    ADD_NONE,
    ADD_HEADINC,
    ADD_PTRINC,
    ADD_ACCUM
  } lls_add_e;

  typedef struct packed {
    logic     rd_en;
    logic     addr_numa;
    logic     ld_next;
    logic     ld_x;
    logic     clr;
    lls_add_e add_sel;
  } lls_ctl_t;

endpackage

// File: rtl/lls_rst_sync.sv
module lls_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/lls_ctrl.sv
module lls_ctrl
  import lls_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  logic     head_zero,
  input  logic     ptr_zero,
  output lls_ctl_t ctl,
  output logic     busy,
  output logic     done
);
  lls_state_e state_q, state_d;

  // next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start) state_d = head_zero ? ST_DONE : ST_HEAD;
      ST_HEAD: state_d = ST_VAL;
      ST_VAL:  state_d = ptr_zero ? ST_TAIL : ST_PTR;
      ST_PTR:  state_d = ST_VAL;
      ST_TAIL: state_d = ST_LAST;
      ST_LAST: state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // control-point decode
  always_comb begin
    ctl = '{rd_en: 1'b0, addr_numa: 1'b0, ld_next: 1'b0, ld_x: 1'b0,
            clr: 1'b0, add_sel: ADD_NONE};
    unique case (state_q)
      ST_IDLE: if (start) begin
        ctl.clr     = 1'b1;
        ctl.add_sel = ADD_HEADINC;
      end
      ST_HEAD: ctl.rd_en = 1'b1;
      ST_VAL: begin
        ctl.rd_en     = 1'b1;
        ctl.addr_numa = 1'b1;
        ctl.ld_next   = 1'b1;
        ctl.add_sel   = ADD_PTRINC;
      end
      ST_PTR: begin
        ctl.rd_en   = 1'b1;
        ctl.ld_x    = 1'b1;
        ctl.add_sel = ADD_ACCUM;
      end
      ST_TAIL: begin
        ctl.ld_x    = 1'b1;
        ctl.add_sel = ADD_ACCUM;
      end
      ST_LAST: ctl.add_sel = ADD_ACCUM;
      default: ;
    endcase
  end

  assign busy = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign done = (state_q == ST_DONE);

  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r6_not_busy_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r7_empty_fast: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && start && head_zero) |=> (done && !ctl.rd_en));
  a_r4_stop_on_null: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_VAL && ptr_zero) |=> (!ctl.rd_en ##1 !ctl.rd_en));
  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && state_q != ST_LAST) |=> busy);
endmodule

// File: rtl/lls_datapath.sv
module lls_datapath
  import lls_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  lls_ctl_t     ctl,
  input  logic [W-1:0] head,
  input  logic [W-1:0] mem_rdata,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] sum,
  output logic         head_zero,
  output logic         ptr_zero
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] next_q, numa_q, x_q, sum_q;
  logic [W-1:0] next_d, numa_d, x_d, sum_d;
  logic         next_en, numa_en, x_en, sum_en;
  logic [W-1:0] add_a, add_b, add_y;

  // the single shared adder
  always_comb begin
    unique case (ctl.add_sel)
      ADD_ACCUM:   begin add_a = sum_q;     add_b = x_q; end
      ADD_HEADINC: begin add_a = head;      add_b = ONE; end
      default:     begin add_a = mem_rdata; add_b = ONE; end
    endcase
    add_y = add_a + add_b;
  end

  // register next values and clock enables
  always_comb begin
    next_en = ctl.clr | ctl.ld_next;
    next_d  = ctl.clr ? head : mem_rdata;
    numa_en = (ctl.add_sel == ADD_HEADINC) | (ctl.add_sel == ADD_PTRINC);
    numa_d  = add_y;
    x_en    = ctl.clr | ctl.ld_x;
    x_d     = ctl.clr ? '0 : mem_rdata;
    sum_en  = ctl.clr | (ctl.add_sel == ADD_ACCUM);
    sum_d   = ctl.clr ? '0 : add_y;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_q <= '0;
      numa_q <= '0;
      x_q    <= '0;
      sum_q  <= '0;
    end else begin
      if (next_en) next_q <= next_d;
      if (numa_en) numa_q <= numa_d;
      if (x_en)    x_q    <= x_d;
      if (sum_en)  sum_q  <= sum_d;
    end
  end

  assign mem_addr  = ctl.addr_numa ? numa_q : next_q;
  assign sum       = sum_q;
  assign head_zero = (head == '0);
  assign ptr_zero  = (mem_rdata == '0);

  a_r3_val_after_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.rd_en && ctl.addr_numa) |-> (mem_addr == $past(mem_addr) + ONE));
  a_r3_ptr_follows_link: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.rd_en && !ctl.addr_numa && $past(ctl.ld_next)) |-> (mem_addr == $past(mem_rdata)));
endmodule

// File: rtl/lls_sum_engine.sv
module lls_sum_engine
  import lls_pkg::*;
#(
  parameter int W          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] head,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] sum,
  output logic         mem_rd_en,
  output logic [W-1:0] mem_addr,
  input  logic [W-1:0] mem_rdata
);
  logic     srst_n;
  lls_ctl_t ctl;
  logic     head_zero, ptr_zero;

  lls_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  lls_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (srst_n),
    .start     (start),
    .head_zero (head_zero),
    .ptr_zero  (ptr_zero),
    .ctl       (ctl),
    .busy      (busy),
    .done      (done)
  );

  lls_datapath #(.W(W)) u_dp (
    .clk       (clk),
    .rst_n     (srst_n),
    .ctl       (ctl),
    .head      (head),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .sum       (sum),
    .head_zero (head_zero),
    .ptr_zero  (ptr_zero)
  );

  assign mem_rd_en = ctl.rd_en;

  a_r9_sum_hold: assert property (@(posedge clk) disable iff (!srst_n)
    (!busy && !start) |=> $stable(sum));
  a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!srst_n)
    (!busy) |-> !mem_rd_en);
endmodule

// File: tb/tb_lls_sum_engine.sv
`timescale 1ns/1ps
module tb_lls_sum_engine;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [15:0] head;
  logic        busy, done, mem_rd_en;
  logic [15:0] sum, mem_addr;
  logic [15:0] mem_rdata;
  logic [15:0] mem [0:255];

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  lls_sum_engine dut (
    .clk(clk), .rst_n(rst_n), .start(start), .head(head),
    .busy(busy), .done(done), .sum(sum),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
  );

  always_ff @(posedge clk) if (mem_rd_en) mem_rdata <= mem[mem_addr[7:0]];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference: per-cycle trace queues
  int          q_rd[$], q_addr[$], q_busy[$], q_done[$], q_kind[$];
  logic [15:0] ref_sum;

  task automatic push(int rd, int a, int b, int d, int k);
    q_rd.push_back(rd); q_addr.push_back(a); q_busy.push_back(b);
    q_done.push_back(d); q_kind.push_back(k);
  endtask

  task automatic plan(logic [15:0] h);
    logic [15:0] p;
    q_rd.delete(); q_addr.delete(); q_busy.delete(); q_done.delete(); q_kind.delete();
    ref_sum = 16'h0;
    if (h == 0) begin
      push(0, 0, 0, 1, 5);
      return;
    end
    p = h;
    push(1, p, 1, 0, 0);
    for (int guard = 0; guard < 100; guard++) begin
      ref_sum = ref_sum + mem[p[7:0] + 8'd1];
      push(1, p + 1, 1, 0, 1);
      if (mem[p[7:0]] == 0) break;
      p = mem[p[7:0]];
      push(1, p, 1, 0, 2);
    end
    push(0, 0, 1, 0, 3);
    push(0, 0, 1, 0, 3);
    push(0, 0, 0, 1, 4);
  endtask

  function automatic string tag(int k);
    case (k)
      0: return "R2";
      1, 2: return "R3";
      3: return "R4";
      4: return "R6";
      default: return "R7";
    endcase
  endfunction

  // run one walk; intrude>0 pulses start with a bogus head at that trace index (R8)
  task automatic run(logic [15:0] h, int intrude);
    plan(h);
    @(negedge clk);
    start = 1'b1; head = h;
    for (int i = 0; i < q_rd.size(); i++) begin
      @(negedge clk);
      start = 1'b0; head = 16'h0;
      if (intrude > 0 && i == intrude) begin start = 1'b1; head = 16'h00C8; end
      check({tag(q_kind[i]), " rd_en"}, mem_rd_en, q_rd[i]);
      if (q_rd[i] != 0) check({tag(q_kind[i]), " addr"}, mem_addr, q_addr[i]);
      check(intrude > 0 ? "R8 busy" : "R6 busy", busy, q_busy[i]);
      check("R6 done", done, q_done[i]);
      if (q_done[i] != 0) check(q_kind[i] == 5 ? "R7 sum" : "R5 sum", sum, ref_sum);
    end
    start = 1'b0; head = 16'h0;
    repeat (3) begin
      @(negedge clk);
      check("R9 sum held", sum, ref_sum);
      check("R6 done low", done, 0);
      check("R4 no read", mem_rd_en, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0;
    // single node at 10
    mem[10] = 16'h0; mem[11] = 16'h0007;
    // four nodes: 20 -> 40 -> 30 -> 60, one value is zero
    mem[20] = 16'd40; mem[21] = 16'h0011;
    mem[40] = 16'd30; mem[41] = 16'h0000;
    mem[30] = 16'd60; mem[31] = 16'h0123;
    mem[60] = 16'd0;  mem[61] = 16'h1000;
    // wrapping sum: 100 -> 110
    mem[100] = 16'd110; mem[101] = 16'hFFF0;
    mem[110] = 16'd0;   mem[111] = 16'h0025;
    // adjacent nodes near the top: 250 -> 252
    mem[250] = 16'd252; mem[251] = 16'h0002;
    mem[252] = 16'd0;   mem[253] = 16'h0003;

    rst_n = 1'b0; start = 1'b0; head = 16'h0;
    repeat (3) @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 rd_en", mem_rd_en, 0);
    check("R1 sum", sum, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 busy after release", busy, 0);
    check("R1 sum after release", sum, 0);

    run(16'd0, 0);     // empty list, R7
    run(16'd10, 0);    // one node
    run(16'd20, 0);    // several nodes
    run(16'd100, 0);   // wrap, R5
    run(16'd250, 0);   // adjacent nodes
    run(16'd20, 3);    // start pulse mid-walk, R8
    run(16'd0, 0);     // empty again after a result, sum cleared

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule